// File: doc/BRIEF.md
# Non-Blocking Load Miss Tracker with Register Scoreboard

This block lets an in-order pipeline retire a load that missed in the L1 data cache without waiting for the data. A load arrives only after its address translation and permission check have succeeded, so it can no longer fault. It takes a free tracking slot, which records the cache line address and the destination register. A scoreboard then marks that register as busy. The load can leave the pipeline at once. Later instructions that do not read a busy register, stores included, keep issuing. Any instruction that reads a busy register holds the issue stage until the data comes back.

Fill responses come back tagged with the slot index. In the cycle of the fill, the block drives the register file write port with the recorded destination. At the next clock edge it releases the slot and clears the busy bit. A pipeline rollback squashes only the instruction currently at issue. Slots that are already allocated stay in place, and so do their register links. Stores can probe the line addresses of the outstanding slots to find a conflict on the same line.

Top module: `ldm_tracker`

## Requirements
- R1: After reset, no slot is in use and no register is busy. An issuing instruction is not stalled, `alloc_valid` is 0 and `probe_hit` is 0.
- R2: A miss load that is accepted (`iss_valid`, `iss_is_miss`, no stall, no rollback) asserts `alloc_valid` in the same cycle. `alloc_idx` names the lowest-numbered free slot, and that slot is in use from the next cycle.
- R3: An instruction whose enabled source (`iss_rs1` with `iss_rs1_en`, or `iss_rs2` with `iss_rs2_en`) names a busy register drives `iss_stall` high.
- R4: An instruction whose enabled sources name no busy register is not stalled, even while misses are outstanding.
- R5: Register 0 never becomes busy. A miss load to register 0 still takes a slot, but its fill asserts no register file write.
- R6: When all 4 slots are in use, a miss load stalls. An instruction that is not a miss load is not stalled by this condition.
- R7: A miss load whose destination register is already busy stalls and takes no slot.
- R8: A fill on an in-use slot drives `rf_wr_en`=1 in the same cycle, with `rf_wr_addr` set to the slot's recorded register and `rf_wr_data` set to `fill_data`. From the next cycle the register is no longer busy and the slot is free.
- R9: `rollback` prevents allocation for the instruction at issue (`alloc_valid`=0). Slots that are already in use, and their busy registers, are unaffected.
- R10: `probe_hit` is 1 exactly when `probe_line` equals the line address of an in-use slot. It drops once that slot's fill has been taken.
- R11: A fill whose index names a free slot is ignored: there is no register file write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction present at issue |
| iss_rs1_en | input | 1 | First source is read |
| iss_rs1 | input | 5 | First source register |
| iss_rs2_en | input | 1 | Second source is read |
| iss_rs2 | input | 5 | Second source register |
| iss_is_miss | input | 1 | Instruction is a translated load that missed the cache |
| iss_rd | input | 5 | Destination register of the miss load |
| iss_line | input | 26 | Line address of the miss load |
| rollback | input | 1 | Squash the instruction at issue |
| iss_stall | output | 1 | Hold the issue stage |
| alloc_valid | output | 1 | A slot is taken this cycle |
| alloc_idx | output | 2 | Index of the slot taken |
| fill_valid | input | 1 | Fill response present |
| fill_idx | input | 2 | Slot index of the fill |
| fill_data | input | 32 | Returned load data |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_addr | output | 5 | Register file write address |
| rf_wr_data | output | 32 | Register file write data |
| probe_line | input | 26 | Line address from a committing store |
| probe_hit | output | 1 | Store line matches an outstanding miss |

## Verification
The bench fills every slot and then checks that a fifth miss stalls while an independent instruction keeps flowing. A design that counted its free slots wrong would either overwrite a live slot or freeze all issue. It also sends a second miss aimed at an already busy register; a design that missed this case would leave two writes in flight to one register. A rollback is applied while misses are outstanding, which would catch a design that drops the live slots. Finally, it fills a slot that holds register 0, and then fills an index whose slot is already free. A faulty design would produce a stray register write in either case, and the scoreboard monitor reports that write as unexpected.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
    parameter int NREG    = 32;
    parameter int ENTRIES = 4;
    parameter int LINEW   = 26;
    parameter int DATAW   = 32;
    localparam int REGW   = $clog2(NREG);
    localparam int IDXW   = $clog2(ENTRIES);

    typedef logic [REGW-1:0]  reg_idx_t;
    typedef logic [IDXW-1:0]  slot_idx_t;
    typedef logic [LINEW-1:0] line_t;
    typedef logic [DATAW-1:0] word_t;

    typedef struct packed {
        logic     used;
        line_t    line;
        reg_idx_t rd;
    } slot_t;

    typedef struct packed {
        logic      found;
        slot_idx_t idx;
    } pick_t;

    // lowest-numbered slot that is not in use
    function automatic pick_t lowest_free(input logic [ENTRIES-1:0] busy);
        pick_t res;
        res = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                res.found = 1'b1;
                res.idx   = slot_idx_t'(i);
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/ldm_scoreboard.sv
module ldm_scoreboard
    import ldm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  reg_idx_t        set_reg,
    input  logic            clr_en,
    input  reg_idx_t        clr_reg,
    input  logic            q_rs1_en,
    input  reg_idx_t        q_rs1,
    input  logic            q_rs2_en,
    input  reg_idx_t        q_rs2,
    input  reg_idx_t        q_rd,
    output logic            src_busy,
    output logic            rd_busy,
    output logic [NREG-1:0] pend
);
    for (genvar g = 0; g < NREG; g++) begin : g_bit
        if (g == 0) begin : g_zero
            assign pend[g] = 1'b0;
        end else begin : g_reg
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (set_en && set_reg == reg_idx_t'(g))
                    bit_q <= 1'b1;
                else if (clr_en && clr_reg == reg_idx_t'(g))
                    bit_q <= 1'b0;
            end
            assign pend[g] = bit_q;
        end
    end

    always_comb begin
        src_busy = (q_rs1_en && pend[q_rs1]) || (q_rs2_en && pend[q_rs2]);
        rd_busy  = pend[q_rd];
    end
endmodule

// File: rtl/ldm_slot_table.sv
module ldm_slot_table
    import ldm_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      alloc_en,
    input  line_t                     alloc_line,
    input  reg_idx_t                  alloc_rd,
    input  logic                      fill_valid,
    input  slot_idx_t                 fill_idx,
    output logic [ENTRIES-1:0]        busy,
    output logic [ENTRIES-1:0][LINEW-1:0] lines,
    output pick_t                     free_pick,
    output logic                      fill_hit,
    output reg_idx_t                  fill_rd
);
    slot_t [ENTRIES-1:0] slot_q;

    always_comb free_pick = lowest_free(busy);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic take, drop;
        assign take = alloc_en && free_pick.found && free_pick.idx == slot_idx_t'(g);
        assign drop = fill_valid && fill_idx == slot_idx_t'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (take) begin
                slot_q[g].used <= 1'b1;
                slot_q[g].line <= alloc_line;
                slot_q[g].rd   <= alloc_rd;
            end else if (drop) begin
                slot_q[g].used <= 1'b0;
            end
        end
        assign busy[g]  = slot_q[g].used;
        assign lines[g] = slot_q[g].line;
    end

    always_comb begin
        fill_hit = fill_valid && slot_q[fill_idx].used;
        fill_rd  = slot_q[fill_idx].rd;
    end
endmodule

// File: rtl/ldm_line_probe.sv
module ldm_line_probe
    import ldm_pkg::*;
(
    input  logic [ENTRIES-1:0]            busy,
    input  logic [ENTRIES-1:0][LINEW-1:0] lines,
    input  line_t                         probe_line,
    output logic                          probe_hit
);
    logic [ENTRIES-1:0] match;
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = busy[g] && lines[g] == probe_line;
    end
    assign probe_hit = |match;
endmodule

// File: rtl/ldm_tracker.sv
module ldm_tracker
    import ldm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      iss_valid,
    input  logic      iss_rs1_en,
    input  reg_idx_t  iss_rs1,
    input  logic      iss_rs2_en,
    input  reg_idx_t  iss_rs2,
    input  logic      iss_is_miss,
    input  reg_idx_t  iss_rd,
    input  line_t     iss_line,
    input  logic      rollback,
    output logic      iss_stall,
    output logic      alloc_valid,
    output slot_idx_t alloc_idx,
    input  logic      fill_valid,
    input  slot_idx_t fill_idx,
    input  word_t     fill_data,
    output logic      rf_wr_en,
    output reg_idx_t  rf_wr_addr,
    output word_t     rf_wr_data,
    input  line_t     probe_line,
    output logic      probe_hit
);
    logic                          src_busy, rd_busy, fill_hit;
    logic [NREG-1:0]               pend;
    logic [ENTRIES-1:0]            busy;
    logic [ENTRIES-1:0][LINEW-1:0] lines;
    pick_t                         free_pick;
    reg_idx_t                      fill_rd;
    logic                          take;

    always_comb begin
        iss_stall = iss_valid &&
                    (src_busy || (iss_is_miss && (rd_busy || !free_pick.found)));
        take      = iss_valid && iss_is_miss && !iss_stall && !rollback;
        alloc_valid = take;
        alloc_idx   = free_pick.idx;
        rf_wr_en    = fill_hit && fill_rd != '0;
        rf_wr_addr  = fill_rd;
        rf_wr_data  = fill_data;
    end

    ldm_scoreboard u_sb (
        .clk      (clk),
        .rst      (rst),
        .set_en   (take && iss_rd != '0),
        .set_reg  (iss_rd),
        .clr_en   (fill_hit),
        .clr_reg  (fill_rd),
        .q_rs1_en (iss_rs1_en),
        .q_rs1    (iss_rs1),
        .q_rs2_en (iss_rs2_en),
        .q_rs2    (iss_rs2),
        .q_rd     (iss_rd),
        .src_busy (src_busy),
        .rd_busy  (rd_busy),
        .pend     (pend)
    );

    ldm_slot_table u_tab (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (take),
        .alloc_line (iss_line),
        .alloc_rd   (iss_rd),
        .fill_valid (fill_valid),
        .fill_idx   (fill_idx),
        .busy       (busy),
        .lines      (lines),
        .free_pick  (free_pick),
        .fill_hit   (fill_hit),
        .fill_rd    (fill_rd)
    );

    ldm_line_probe u_probe (
        .busy       (busy),
        .lines      (lines),
        .probe_line (probe_line),
        .probe_hit  (probe_hit)
    );
endmodule

// File: rtl/ldm_tracker_chk.sv
module ldm_tracker_chk
    import ldm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               iss_valid,
    input logic               iss_rs1_en,
    input reg_idx_t           iss_rs1,
    input logic               iss_is_miss,
    input logic               rollback,
    input logic               iss_stall,
    input logic               alloc_valid,
    input slot_idx_t          alloc_idx,
    input logic               fill_valid,
    input slot_idx_t          fill_idx,
    input logic               probe_hit,
    input logic [NREG-1:0]    pend,
    input logic [ENTRIES-1:0] busy
);
    // R2
    alloc_lands_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |=> busy[$past(alloc_idx)]);
    // R2
    alloc_free_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> !busy[alloc_idx]);
    // R3
    src_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_rs1_en && pend[iss_rs1]) |-> iss_stall);
    // R6
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_is_miss && (&busy)) |-> iss_stall);
    // R8
    fill_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && busy[fill_idx]) |=> !busy[$past(fill_idx)]);
    // R9
    rollback_chk: assert property (@(posedge clk) disable iff (rst)
        rollback |-> !alloc_valid);
    // R10
    probe_live_chk: assert property (@(posedge clk) disable iff (rst)
        probe_hit |-> (|busy));
endmodule

bind ldm_tracker ldm_tracker_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .iss_valid   (iss_valid),
    .iss_rs1_en  (iss_rs1_en),
    .iss_rs1     (iss_rs1),
    .iss_is_miss (iss_is_miss),
    .rollback    (rollback),
    .iss_stall   (iss_stall),
    .alloc_valid (alloc_valid),
    .alloc_idx   (alloc_idx),
    .fill_valid  (fill_valid),
    .fill_idx    (fill_idx),
    .probe_hit   (probe_hit),
    .pend        (pend),
    .busy        (busy)
);

// File: tb/ldm_tracker_test.sv
module ldm_tracker_test;
    logic        clk = 0, rst = 1;
    logic        iss_valid = 0, iss_rs1_en = 0, iss_rs2_en = 0, iss_is_miss = 0, rollback = 0;
    logic [4:0]  iss_rs1 = 0, iss_rs2 = 0, iss_rd = 0;
    logic [25:0] iss_line = 0, probe_line = 0;
    logic        iss_stall, alloc_valid, fill_valid = 0, rf_wr_en, probe_hit;
    logic [1:0]  alloc_idx, fill_idx = 0;
    logic [31:0] fill_data = 0, rf_wr_data;
    logic [4:0]  rf_wr_addr;

    int checks = 0, failures = 0;
    bit done = 0;

    typedef struct { logic [4:0] a; logic [31:0] d; } wr_t;
    wr_t exp_q[$];

    always #5 clk = ~clk;

    ldm_tracker uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every register file write must match the next expected item
    always @(negedge clk) begin
        if (!rst && rf_wr_en) begin
            if (exp_q.size() == 0) begin
                chk(0, "R5/R11 unexpected write", {27'd0, rf_wr_addr}, 0);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk(rf_wr_addr == e.a && rf_wr_data == e.d, "R8 write",
                    {rf_wr_addr, rf_wr_data[26:0]}, {e.a, e.d[26:0]});
            end
        end
    end

    task automatic quiet();
        iss_valid = 0; iss_rs1_en = 0; iss_rs2_en = 0; iss_is_miss = 0;
        rollback = 0; fill_valid = 0;
    endtask

    task automatic rd_op(input logic [4:0] a, input logic [4:0] b);
        quiet(); iss_valid = 1; iss_rs1_en = 1; iss_rs1 = a; iss_rs2_en = 1; iss_rs2 = b; #1;
    endtask

    task automatic miss(input logic [4:0] rd, input logic [25:0] line);
        quiet(); iss_valid = 1; iss_is_miss = 1; iss_rd = rd; iss_line = line; #1;
    endtask

    task automatic fill(input logic [1:0] idx, input logic [31:0] d);
        quiet(); fill_valid = 1; fill_idx = idx; fill_data = d; #1;
    endtask

    task automatic step();
        @(posedge clk); #1;
        quiet();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1
        rd_op(5, 6); probe_line = 26'h100;
        chk(!iss_stall && !alloc_valid && !probe_hit, "R1 reset", {iss_stall, alloc_valid, probe_hit}, 0);
        step();
        // R2
        miss(5, 26'h100);
        chk(!iss_stall && alloc_valid && alloc_idx == 0, "R2 alloc slot0", {alloc_valid, alloc_idx}, 3'b100);
        step();
        rd_op(5, 9);  chk(iss_stall, "R3 rs1 busy", iss_stall, 1);
        rd_op(9, 5);  chk(iss_stall, "R3 rs2 busy", iss_stall, 1);
        rd_op(6, 7);  chk(!iss_stall, "R4 independent", iss_stall, 0);
        probe_line = 26'h100; #1; chk(probe_hit, "R10 probe match", probe_hit, 1);
        probe_line = 26'h200; #1; chk(!probe_hit, "R10 probe other", probe_hit, 0);
        miss(0, 26'h200);
        chk(alloc_valid && alloc_idx == 1, "R2 alloc slot1 r0", alloc_idx, 1);
        step();
        rd_op(0, 0); chk(!iss_stall, "R5 r0 never busy", iss_stall, 0);
        miss(5, 26'h300);
        chk(iss_stall && !alloc_valid, "R7 busy dest", {iss_stall, alloc_valid}, 2'b10);
        step();
        miss(6, 26'h300); chk(alloc_idx == 2 && alloc_valid, "R2 slot2", alloc_idx, 2); step();
        miss(7, 26'h400); chk(alloc_idx == 3 && alloc_valid, "R2 slot3", alloc_idx, 3); step();
        miss(8, 26'h500); chk(iss_stall && !alloc_valid, "R6 full stalls miss", iss_stall, 1);
        rd_op(9, 10); chk(!iss_stall, "R6 non-miss flows", iss_stall, 0);
        step();
        // R9: rollback with a free slot
        fill(2, 32'hC0DE_0006);
        exp_q.push_back('{5'd6, 32'hC0DE_0006});
        chk(rf_wr_en && rf_wr_addr == 6, "R8 fill same cycle", rf_wr_addr, 6);
        step();
        rd_op(6, 6); chk(!iss_stall, "R8 reg released", iss_stall, 0);
        probe_line = 26'h300; #1; chk(!probe_hit, "R10 probe after fill", probe_hit, 1'b0);
        miss(9, 26'h600); rollback = 1; #1;
        chk(!alloc_valid, "R9 rollback squash", alloc_valid, 0);
        step();
        rd_op(9, 9); chk(!iss_stall, "R9 squashed not busy", iss_stall, 0);
        rd_op(5, 7); chk(iss_stall, "R9 live slot kept", iss_stall, 1);
        miss(8, 26'h500);
        chk(alloc_valid && alloc_idx == 2, "R2 reuse lowest free", alloc_idx, 2);
        step();
        fill(1, 32'hDEAD_0000); chk(!rf_wr_en, "R5 r0 fill no write", rf_wr_en, 0); step();
        fill(1, 32'hBAD0_0001); chk(!rf_wr_en, "R11 free slot fill", rf_wr_en, 0); step();
        fill(0, 32'h1111_0005); exp_q.push_back('{5'd5, 32'h1111_0005}); step();
        fill(3, 32'h3333_0007); exp_q.push_back('{5'd7, 32'h3333_0007}); step();
        fill(2, 32'h2222_0008); exp_q.push_back('{5'd8, 32'h2222_0008}); step();
        rd_op(5, 8); chk(!iss_stall, "R8 all released", iss_stall, 0);
        chk(exp_q.size() == 0, "R8 writes drained", exp_q.size(), 0);
        step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule